// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps calendar time (seconds, minutes, hours, day of week, date, month and two-digit year) as packed BCD counters, with tens and units digits in separate nibbles. A base tick input is divided by a parameterised prescaler. Each time the prescaler completes a full count, the time moves on by one second, with full carry through to the year. Date rollover follows the length of each month, and February gains a 29th day in leap years.

Software reaches the block through a register port with nine registers. Register 0 holds the flags and control bits, register 1 holds oscillator, tamper-sense and calibration control, and registers 2 to 8 hold time. Time reads never touch the live counters. Setting the read bit copies the time into a holding latch, and reads of registers 2 to 8 return that latch. Time writes go to staging registers while the write bit is set. Clearing the write bit moves the staged time into the counters in one cycle and restarts the prescaler.

Top module: `bcd_calendar_core`

## Requirements
- R1: After a synchronous active-low reset, registers 0 and 1 read 0x00. A capture then returns 00:00:00, day 1, date 01, month 01, year 00.
- R2: Time fields use these layouts: seconds and minutes as {0, tens[2:0], units[3:0]}, hours and date as {00, tens[1:0], units}, day as {00000, day[2:0]}, month as {000, tens bit, units}, and year as {tens, units}. Bits outside a field are dropped on write and read as 0. Register 0 reads {tamper, century, 0, 0, test, calmode, W, R}, with W at D1 and R at D0. Test and calmode read back as written.
- R3: The seconds count advances exactly once for every TICK_DIV tick pulses, on the clock edge of the final pulse.
- R4: Seconds and minutes roll from 59 to 00 and carry into the next field. Hours roll from 23 to 00 and carry into the day and date.
- R5: The day of week steps at midnight and wraps from 7 to 1.
- R6: The date rolls to 01 and carries into the month after the last day of the month. Months 04, 06, 09 and 11 end on 30, and February ends on 28, or on 29 when the BCD year is divisible by 4 (year 00 counts as a leap year).
- R7: The month rolls from 12 to 01 and increments the year. The year rolls from 99 to 00 and sets the century flag (register 0, D6). Writing 0 to D6 clears the flag. Writing 1 to D6 has no effect.
- R8: A 0-to-1 write of R (register 0, D0) copies the live time into the holding latch. Reads of registers 2 to 8 return the latch and do not change while time advances until the next 0-to-1 write of R.
- R9: A 0-to-1 write of W (register 0, D1) loads the staging registers from the live time. Time writes while W is 0 are ignored. A 1-to-0 write of W loads the staged time into the counters and restarts the tick phase.
- R10: While register 1 D7 is 1 (oscillator disabled), tick pulses have no effect on the time or on the tick phase.
- R11: Addresses 9 to 15 read 0x00, and writes to them change no register.
- R12: The tamper flag (register 0, D7) is set while tamper_in is high and the tamper-sense enable (register 1, D6) is 1. It is ignored while the enable is 0. Writing 0 to D7 clears the flag once tamper_in is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Base tick pulse, one clock wide |
| tamper_in | input | 1 | Tamper event level from the sensing circuit |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe for bus_wdata into bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The assertions expect every value software writes into a time field to be a valid BCD value for that field after masking: a valid date for its month, a day from 1 to 7, an hour below 24, and so on. They also expect tick pulses never to coincide with a write that transfers time. The bench draws random times from these legal ranges only, converts them to BCD itself, and sends ticks only in cycles when no bus write is under way. The directed cases go right up to the edges of these ranges: month ends, leap and non-leap February, and year 99 to 00.

// File: rtl/bcd_cal_pkg.sv
// Package: shared time record, field masks and BCD helpers for the calendar core.
// Assumes every field holds valid packed BCD (tens nibble high, units nibble low).
package bcd_cal_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    localparam logic [7:0] SEC_MASK   = 8'h7F;
    localparam logic [7:0] MIN_MASK   = 8'h7F;
    localparam logic [7:0] HOUR_MASK  = 8'h3F;
    localparam logic [7:0] DAY_MASK   = 8'h07;
    localparam logic [7:0] DATE_MASK  = 8'h3F;
    localparam logic [7:0] MONTH_MASK = 8'h1F;
    localparam logic [7:0] YEAR_MASK  = 8'hFF;

    localparam cal_time_t TIME_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                         day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

    // Add one to a two-digit BCD value (no wrap at 99; callers handle wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test on a BCD year: divisible by 4.
    function automatic logic bcd_leap(input logic [7:0] y);
        if (y[4] == 1'b0) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last valid date of a BCD month in a BCD year.
    function automatic logic [7:0] bcd_last_date(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_tick_prescaler.sv
// Module: divides base tick pulses into one-second advance pulses.
// Assumes tick_i is a one-cycle pulse; clear_i restarts the phase at zero.
module cal_tick_prescaler #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic enable_i,
    input  logic clear_i,
    output logic sec_pulse_o
);
    generate
        if (TICK_DIV <= 1) begin : g_direct
            // Every enabled tick is a second.
            assign sec_pulse_o = tick_i && enable_i && !clear_i;
        end else begin : g_count
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] phase;

            // Track the sub-second phase between enabled ticks.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i)      phase <= '0;
                else if (tick_i && enable_i) phase <= (phase == LAST) ? '0 : phase + 1'b1;
            end

            assign sec_pulse_o = tick_i && enable_i && !clear_i && (phase == LAST);

            // R3
            pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sec_pulse_o |=> !sec_pulse_o);
            // R9
            phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i |=> (phase == '0));
        end
    endgenerate
endmodule

// File: rtl/cal_time_counter.sv
// Module: live BCD calendar counters with full carry chain and month-length rollover.
// Assumes loaded values are valid BCD; load_i has priority over advance_i.
module cal_time_counter
    import bcd_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      advance_i,
    input  logic      load_i,
    input  cal_time_t load_val_i,
    output cal_time_t live_o,
    output logic      year_wrap_o
);
    cal_time_t live, nxt;
    logic sec_w, min_w, hour_w, date_w, month_w, year_w;

    // Compute the time one second later and the carries between fields.
    always_comb begin
        sec_w   = (live.sec == 8'h59);
        min_w   = sec_w && (live.min == 8'h59);
        hour_w  = min_w && (live.hour == 8'h23);
        date_w  = hour_w && (live.date == bcd_last_date(live.month, live.year));
        month_w = date_w && (live.month == 8'h12);
        year_w  = month_w && (live.year == 8'h99);
        nxt       = live;
        nxt.sec   = sec_w ? 8'h00 : bcd_inc(live.sec);
        if (sec_w)   nxt.min   = min_w ? 8'h00 : bcd_inc(live.min);
        if (min_w)   nxt.hour  = hour_w ? 8'h00 : bcd_inc(live.hour);
        if (hour_w)  nxt.day   = (live.day == 8'h07) ? 8'h01 : live.day + 8'h01;
        if (hour_w)  nxt.date  = date_w ? 8'h01 : bcd_inc(live.date);
        if (date_w)  nxt.month = month_w ? 8'h01 : bcd_inc(live.month);
        if (month_w) nxt.year  = year_w ? 8'h00 : bcd_inc(live.year);
    end

    // Hold, load or advance the live time.
    always_ff @(posedge clk) begin
        if (!rst_n)         live <= TIME_RESET;
        else if (load_i)    live <= load_val_i;
        else if (advance_i) live <= nxt;
    end

    assign live_o      = live;
    assign year_wrap_o = advance_i && !load_i && year_w;

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i && live.sec == 8'h59) |=> (live.sec == 8'h00));
    // R4
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live.hour[3:0] <= 4'd9) && (live.hour < 8'h24));
    // R5
    day_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live.day >= 8'h01) && (live.day <= 8'h07));
    // R6
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live.date != 8'h00) && (live.date <= 8'h31));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !load_i) |=> $stable(live));
endmodule

// File: rtl/cal_reg_bank.sv
// Module: register decode, flags/control bits, read-capture latch and write-staging latch.
// Assumes one bus access per cycle; time reads come from the capture latch only.
module cal_reg_bank
    import bcd_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [3:0] addr_i,
    input  logic      wr_i,
    input  logic [7:0] wdata_i,
    input  logic      tamper_i,
    input  logic      year_wrap_i,
    input  cal_time_t live_i,
    output logic [7:0] rdata_o,
    output logic      load_o,
    output cal_time_t stage_o,
    output logic      osc_en_o
);
    logic      tamper_f, century_f, test_b, calm_b, w_b, r_b;
    logic [7:0] ctrl;
    cal_time_t cap, stage;
    logic      wr0, wr1, cap_en, stage_en;
    logic      unused_bits;

    assign wr0      = wr_i && (addr_i == 4'd0);
    assign wr1      = wr_i && (addr_i == 4'd1);
    assign cap_en   = wr0 && wdata_i[0] && !r_b;
    assign stage_en = wr0 && wdata_i[1] && !w_b;
    assign load_o   = wr0 && !wdata_i[1] && w_b;
    assign unused_bits = ^wdata_i[5:4];

    // Register 0 control bits and the two sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {tamper_f, century_f, test_b, calm_b, w_b, r_b} <= '0;
        end else begin
            if (wr0) {test_b, calm_b, w_b, r_b} <= wdata_i[3:0];
            if (tamper_i && ctrl[6])       tamper_f <= 1'b1;
            else if (wr0 && !wdata_i[7])   tamper_f <= 1'b0;
            if (year_wrap_i)               century_f <= 1'b1;
            else if (wr0 && !wdata_i[6])   century_f <= 1'b0;
        end
    end

    // Register 1: oscillator disable, tamper enable, calibration sign and value.
    always_ff @(posedge clk) begin
        if (!rst_n)   ctrl <= 8'h00;
        else if (wr1) ctrl <= wdata_i;
    end

    // Read latch: snapshot live time on a rising read bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap <= TIME_RESET;
        else if (cap_en) cap <= live_i;
    end

    // Staging latch: seed from live time on a rising write bit, then take field writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= TIME_RESET;
        end else if (stage_en) begin
            stage <= live_i;
        end else if (wr_i && w_b) begin
            case (addr_i)
                4'd2: stage.sec   <= wdata_i & SEC_MASK;
                4'd3: stage.min   <= wdata_i & MIN_MASK;
                4'd4: stage.hour  <= wdata_i & HOUR_MASK;
                4'd5: stage.day   <= wdata_i & DAY_MASK;
                4'd6: stage.date  <= wdata_i & DATE_MASK;
                4'd7: stage.month <= wdata_i & MONTH_MASK;
                4'd8: stage.year  <= wdata_i & YEAR_MASK;
                default: ;
            endcase
        end
    end

    // Read decode.
    always_comb begin
        case (addr_i)
            4'd0:    rdata_o = {tamper_f, century_f, 2'b00, test_b, calm_b, w_b, r_b};
            4'd1:    rdata_o = ctrl;
            4'd2:    rdata_o = cap.sec;
            4'd3:    rdata_o = cap.min;
            4'd4:    rdata_o = cap.hour;
            4'd5:    rdata_o = cap.day;
            4'd6:    rdata_o = cap.date;
            4'd7:    rdata_o = cap.month;
            4'd8:    rdata_o = cap.year;
            default: rdata_o = 8'h00;
        endcase
    end

    assign stage_o  = stage;
    assign osc_en_o = !ctrl[7];

    // R7
    century_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        year_wrap_i |=> century_f);
    // R8
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr0 && wdata_i[0] && !r_b) |=> $stable(cap));
    // R12
    tamper_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_i && ctrl[6]) |=> tamper_f);
    // R9
    load_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !w_b);
endmodule

// File: rtl/bcd_calendar_core.sv
// Module: top of the BCD calendar clock register file.
// Joins the tick prescaler, the live counters and the register bank.
// Assumes ticks and time-transfer writes do not fall in the same cycle.
module bcd_calendar_core #(
    parameter int TICK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       tamper_in,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    import bcd_cal_pkg::*;

    cal_time_t live, stage;
    logic      sec_pulse, load, osc_en, year_wrap;

    cal_tick_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_in), .enable_i(osc_en),
        .clear_i(load), .sec_pulse_o(sec_pulse)
    );

    cal_time_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .advance_i(sec_pulse), .load_i(load),
        .load_val_i(stage), .live_o(live), .year_wrap_o(year_wrap)
    );

    cal_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .tamper_i(tamper_in), .year_wrap_i(year_wrap),
        .live_i(live), .rdata_o(bus_rdata), .load_o(load), .stage_o(stage),
        .osc_en_o(osc_en)
    );

    // R10
    osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !sec_pulse);
endmodule

// File: tb/bcd_calendar_core_bench.sv
module bcd_calendar_core_bench;
    localparam int DIV = 4;

    logic clk = 0, rst_n = 0, tick_in = 0, tamper_in = 0, bus_wr = 0;
    logic [3:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;

    int checks = 0, fails = 0;
    int m_sec, m_min, m_hour, m_day, m_date, m_mon, m_year, m_phase;
    bit m_osc_off;

    bcd_calendar_core #(.TICK_DIV(DIV)) u_bcd_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tamper_in(tamper_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Bench model of one elapsed second; returns 1 when the year wraps.
    function automatic bit model_second();
        m_sec++;
        if (m_sec < 60) return 0;
        m_sec = 0; m_min++;
        if (m_min < 60) return 0;
        m_min = 0; m_hour++;
        if (m_hour < 24) return 0;
        m_hour = 0; m_day = (m_day == 7) ? 1 : m_day + 1; m_date++;
        if (m_date <= mdays(m_mon, m_year)) return 0;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return 0;
        m_mon = 1; m_year++;
        if (m_year < 100) return 0;
        m_year = 0;
        return 1;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    // Tick pulses; returns 1 in yw if any year wrap happened.
    task automatic ticks(input int n, output bit yw);
        yw = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1;
            @(negedge clk); tick_in = 0;
            if (!m_osc_off) begin
                m_phase++;
                if (m_phase == DIV) begin
                    m_phase = 0;
                    if (model_second()) yw = 1;
                end
            end
        end
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int dw,
                            input int dt, input int mo, input int y);
        wr(0, 8'h02);
        wr(2, to_bcd(s)); wr(3, to_bcd(mi)); wr(4, to_bcd(h)); wr(5, to_bcd(dw));
        wr(6, to_bcd(dt)); wr(7, to_bcd(mo)); wr(8, to_bcd(y));
        wr(0, 8'h00);
        m_sec = s; m_min = mi; m_hour = h; m_day = dw; m_date = dt; m_mon = mo; m_year = y;
        m_phase = 0;
    endtask

    task automatic get_time(output logic [55:0] t);
        logic [7:0] b;
        wr(0, 8'h01);
        for (int a = 8; a >= 2; a--) begin
            rd(4'(a), b); t = {t[47:0], b};
        end
        wr(0, 8'h00);
    endtask

    function automatic logic [55:0] model_bcd();
        return {to_bcd(m_year), to_bcd(m_mon), to_bcd(m_date), to_bcd(m_day),
                to_bcd(m_hour), to_bcd(m_min), to_bcd(m_sec)};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [55:0] t, t0;
        logic [7:0] b;
        bit yw;
        void'($urandom(32'd1234));
        m_osc_off = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(0, b); check("R1 reg0", b, 8'h00);
        rd(1, b); check("R1 reg1", b, 8'h00);
        m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_date = 1; m_mon = 1; m_year = 0; m_phase = 0;
        get_time(t); check("R1 time", t, model_bcd());

        // R2 masking of extra bits and control bits
        wr(0, 8'h02);
        wr(2, 8'hD9); wr(3, 8'hC5); wr(4, 8'hD2); wr(5, 8'hFB);
        wr(6, 8'hD7); wr(7, 8'hE1); wr(8, 8'h42);
        wr(0, 8'h00);
        get_time(t); check("R2 field masks", t, 56'h42_01_17_03_12_45_59);
        wr(0, 8'h3C); rd(0, b); check("R2 reg0 layout", b, 8'h0C);
        wr(0, 8'h00);

        // R3 prescaler
        set_time(10, 20, 5, 3, 15, 6, 30);
        ticks(DIV - 1, yw); get_time(t); check("R3 before last tick", t, 56'h30_06_15_03_05_20_10);
        ticks(1, yw); get_time(t); check("R3 on last tick", t, model_bcd());

        // R4 R5 R6 midnight into leap day
        set_time(59, 59, 23, 7, 28, 2, 24);
        ticks(DIV, yw); get_time(t); check("R4 R5 R6 leap Feb 28", t, 56'h24_02_29_01_00_00_00);
        set_time(59, 59, 23, 4, 28, 2, 23);
        ticks(DIV, yw); get_time(t); check("R6 non-leap Feb 28", t, 56'h23_03_01_05_00_00_00);
        set_time(59, 59, 23, 2, 30, 4, 51);
        ticks(DIV, yw); get_time(t); check("R6 Apr 30", t, 56'h51_05_01_03_00_00_00);
        set_time(59, 59, 23, 1, 29, 2, 0);
        ticks(DIV, yw); get_time(t); check("R6 year 00 leap", t, 56'h00_03_01_02_00_00_00);
        set_time(59, 59, 9, 1, 5, 5, 5);
        ticks(DIV, yw); get_time(t); check("R4 hour 09 to 10", t, 56'h05_05_05_01_10_00_00);

        // R7 year wrap and century flag
        set_time(59, 59, 23, 6, 31, 12, 99);
        ticks(DIV, yw);
        rd(0, b); check("R7 century set", b, 8'h40);
        get_time(t); check("R7 new year", t, 56'h00_01_01_07_00_00_00);
        rd(0, b); check("R7 cleared by write 0", b, 8'h00);
        set_time(59, 59, 23, 6, 31, 12, 99);
        ticks(DIV, yw);
        wr(0, 8'h40); rd(0, b); check("R7 write 1 no effect", b, 8'h40);
        wr(0, 8'h00);

        // R8 capture holds while time runs
        set_time(0, 0, 12, 2, 10, 10, 10);
        wr(0, 8'h01);
        ticks(DIV * 3, yw);
        rd(2, b); check("R8 latch frozen", b, 8'h00);
        wr(0, 8'h00); wr(0, 8'h01);
        rd(2, b); check("R8 recapture", b, 8'h03);
        wr(0, 8'h00);

        // R9 writes with W clear ignored; transfer resets phase
        wr(2, 8'h33);
        get_time(t); check("R9 write with W=0 ignored", t, model_bcd());
        ticks(2, yw);
        set_time(0, 30, 8, 4, 1, 7, 77);
        ticks(DIV - 1, yw); get_time(t); check("R9 phase restart", t, 56'h77_07_01_04_08_30_00);
        wr(0, 8'h02); wr(3, 8'h45); wr(0, 8'h00);
        m_min = 45; m_phase = 0;
        get_time(t); check("R9 seeded from live", t, model_bcd());

        // R10 oscillator disabled
        wr(1, 8'h80); m_osc_off = 1;
        get_time(t0); ticks(DIV * 3, yw); get_time(t);
        check("R10 ticks ignored", t, t0);
        rd(1, b); check("R10 reg1 readback", b, 8'h80);
        wr(1, 8'h00); m_osc_off = 0;
        ticks(DIV, yw); get_time(t); check("R10 resumes", t, model_bcd());

        // R11 unmapped addresses
        wr(9, 8'hFF); wr(15, 8'hFF);
        for (int a = 9; a < 16; a++) begin
            rd(4'(a), b); check("R11 unmapped read", b, 8'h00);
        end
        rd(0, b); check("R11 reg0 untouched", b, 8'h00);
        rd(1, b); check("R11 reg1 untouched", b, 8'h00);
        get_time(t); check("R11 time untouched", t, model_bcd());

        // R12 tamper flag
        @(negedge clk); tamper_in = 1; @(negedge clk); tamper_in = 0;
        rd(0, b); check("R12 ignored when disabled", b, 8'h00);
        wr(1, 8'h40);
        @(negedge clk); tamper_in = 1; @(negedge clk); tamper_in = 0;
        rd(0, b); check("R12 set", b, 8'h80);
        wr(0, 8'h00); rd(0, b); check("R12 cleared", b, 8'h00);
        wr(1, 8'h00);

        // Random times and tick counts, R4 R5 R6 R7
        for (int it = 0; it < 40; it++) begin
            int mo, y, n;
            mo = int'($urandom_range(12, 1)); y = int'($urandom_range(99, 0));
            set_time(int'($urandom_range(59, 50)), int'($urandom_range(59, 57)),
                     int'($urandom_range(23, 22)), int'($urandom_range(7, 1)),
                     mdays(mo, y) - int'($urandom_range(1, 0)), mo, y);
            n = int'($urandom_range(DIV * 150, 1));
            ticks(n, yw);
            get_time(t); check("R4 R5 R6 random run", t, model_bcd());
            if (yw) wr(0, 8'h00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule